// File: doc/BRIEF.md
# MSI Line Coherence Controller with Transient States

This block keeps the coherence state of a small direct-mapped set of cache lines on a snooping bus. It uses the three stable states Invalid, Shared and Modified. Any operation that needs the bus parks the line in a transient waiting state until the bus-available grant arrives. The processor side issues Read, Write and Replace requests. The bus side delivers snooped read (Bus_Rd) and read-exclusive (Bus_RdX) transactions and a grant. The controller raises a bus request while an operation is waiting. A line that is waiting still answers snoops.

Every change of a line's architected (stable) state is reported to an external checker one cycle later. The report carries the address, the stable state before and after, the input that caused the change and the action taken. The controller holds at most one outstanding bus operation. Processor requests are stalled while one is waiting.

Each cycle the block consumes at most one event. A snoop comes first, then the grant of the waiting operation, then the processor request. Each line stores a tag and a 3-bit state: Invalid, Shared, Modified, WaitRead (from I, heading to S), WaitRdxI (from I, heading to M), WaitRdxS (from S, heading to M) and WaitWb (from M, heading to I). An event applies to a slot only if its tag matches the stored tag. Otherwise the slot is treated as Invalid for that address.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` is 0 and `rec_valid` is 0. A line that was valid before a reset reports initial state Invalid (0) on its next fill.
- R2: A Read to an Invalid line enters WaitRead. On the grant the line becomes Shared, reported as init I, final S, input BUS_AV, action FILL.
- R3: A Write to an Invalid line enters WaitRdxI, and on the grant it is reported I to M with action FILL. A Write to a Shared line enters WaitRdxS, and on the grant it is reported S to M with action UPGRADE.
- R4: A Replace in Modified enters WaitWb, and on the grant it is reported M to I with input BUS_AV and action FLUSH. A Replace in Shared goes straight to Invalid, reported with input REPLACE and action NONE.
- R5: A snooped Bus_Rd moves a Modified line to Shared with action FLUSH. A snooped Bus_Rd leaves a Shared line unchanged and produces no record.
- R6: A snooped Bus_RdX invalidates a Shared line (action NONE) or a Modified line (action FLUSH).
- R7: A Bus_RdX snooped in WaitRdxS turns the line into WaitRdxI. This is reported S to I (action NONE), and the bus request stays high. The later grant is reported I to M with action FILL.
- R8: Any snoop that hits a line in WaitWb completes the eviction. It is reported M to I with the snoop as input and action FLUSH, and `bus_req` drops.
- R9: `bus_req` is high from the edge that accepts a bus-needing request until the edge that consumes the grant. A grant that arrives in the same cycle as a snoop is not consumed.
- R10: `cpu_stall` is high, and the request has no effect, when `cpu_valid` is set while an operation is waiting, while a snoop is present, or when a Read or Write names a tag other than the one held by a non-Invalid slot.
- R11: These produce no record and no state change: hits (Read in S or M, Write in M), a Replace of an Invalid line, a snoop whose tag does not match the slot, and an idle cycle.
- R12: Records appear one cycle after the event edge as a one-cycle `rec_valid` pulse, and init always differs from final. Stable-state codes are I=0, S=1, M=2. Input codes are READ=0, WRITE=1, REPLACE=2, BUS_RD=3, BUS_RDX=4, BUS_AV=5. Action codes are NONE=0, FILL=1, UPGRADE=2, FLUSH=3. `cpu_op` uses 0=Read, 1=Write, 2=Replace, and 3 is ignored. `snp_op` uses 0=Bus_Rd, 1=Bus_RdX. The slot index is the low `IDX_W` address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Processor operation code |
| cpu_addr | input | ADDR_W | Processor request address |
| cpu_stall | output | 1 | Request not accepted this cycle |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_op | input | 1 | Snoop kind: 0 read, 1 read-exclusive |
| snp_addr | input | ADDR_W | Snooped address |
| bus_grant | input | 1 | Bus available for the waiting operation |
| bus_req | output | 1 | Request for the bus |
| rec_valid | output | 1 | Transition record present |
| rec_addr | output | ADDR_W | Address of the changed line |
| rec_init | output | 2 | Stable state before the change |
| rec_final | output | 2 | Stable state after the change |
| rec_input | output | 3 | Input that caused the change |
| rec_action | output | 2 | Action taken |

## Verification
Several properties are checked on every cycle. A consumed grant always drops the bus request and always yields a BUS_AV record. The request only rises after an accepted processor request. Processor requests stall while an operation waits. Quiet cycles produce no record, snoop cycles only produce snoop-input records, and every FLUSH starts from Modified. The exact state reached on each arc, the addresses in the records, the handling of tag conflicts and mismatched snoops, and the way a reset erases earlier state can only be shown by the bench's sequences of requests, snoops and grants.

// File: rtl/msi_pkg.sv
package msi_pkg;

    // Per-line state: three stable values plus four waiting values.
    typedef enum logic [2:0] {
        LS_INV        = 3'd0,
        LS_SHD        = 3'd1,
        LS_MOD        = 3'd2,
        LS_WAIT_RD    = 3'd3,
        LS_WAIT_RDX_I = 3'd4,
        LS_WAIT_RDX_S = 3'd5,
        LS_WAIT_WB    = 3'd6
    } line_state_e;

    typedef enum logic [1:0] {
        AS_I = 2'd0,
        AS_S = 2'd1,
        AS_M = 2'd2
    } arch_state_e;

    typedef enum logic [2:0] {
        EV_READ    = 3'd0,
        EV_WRITE   = 3'd1,
        EV_REPLACE = 3'd2,
        EV_SNP_RD  = 3'd3,
        EV_SNP_RDX = 3'd4,
        EV_GRANT   = 3'd5
    } event_e;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_FILL    = 2'd1,
        ACT_UPGRADE = 2'd2,
        ACT_FLUSH   = 2'd3
    } action_e;

    // Stable state that the rest of the system sees for a line.
    function automatic arch_state_e arch_of(line_state_e s);
        arch_state_e a;
        unique case (s)
            LS_SHD, LS_WAIT_RDX_S: a = AS_S;
            LS_MOD, LS_WAIT_WB:    a = AS_M;
            default:               a = AS_I;
        endcase
        return a;
    endfunction

    function automatic logic is_waiting(line_state_e s);
        return (s == LS_WAIT_RD) || (s == LS_WAIT_RDX_I) ||
               (s == LS_WAIT_RDX_S) || (s == LS_WAIT_WB);
    endfunction

endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output line_state_e      rd_state,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_state_e      wr_state,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    line_state_e      state_v [LINES];
    logic [TAG_W-1:0] tag_v   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_slot
        line_state_e      st_q;
        logic [TAG_W-1:0] tg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= LS_INV;
                tg_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_q <= wr_state;
                tg_q <= wr_tag;
            end
        end

        assign state_v[g] = st_q;
        assign tag_v[g]   = tg_q;
    end

    assign rd_state = state_v[rd_idx];
    assign rd_tag   = tag_v[rd_idx];

endmodule

// File: rtl/msi_event_select.sv
module msi_event_select
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              snp_valid,
    input  logic              snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              bus_grant,
    input  logic              pend_busy,
    input  logic [ADDR_W-1:0] pend_addr,
    output logic              ev_valid,
    output event_e            ev_kind,
    output logic [ADDR_W-1:0] ev_addr
);
    // Priority: snoop, then grant of the waiting line, then processor.
    always_comb begin
        ev_valid = 1'b0;
        ev_kind  = EV_READ;
        ev_addr  = cpu_addr;
        if (snp_valid) begin
            ev_valid = 1'b1;
            ev_kind  = snp_op ? EV_SNP_RDX : EV_SNP_RD;
            ev_addr  = snp_addr;
        end else if (pend_busy && bus_grant) begin
            ev_valid = 1'b1;
            ev_kind  = EV_GRANT;
            ev_addr  = pend_addr;
        end else if (!pend_busy && cpu_valid) begin
            unique case (cpu_op)
                2'd0: begin ev_valid = 1'b1; ev_kind = EV_READ;    end
                2'd1: begin ev_valid = 1'b1; ev_kind = EV_WRITE;   end
                2'd2: begin ev_valid = 1'b1; ev_kind = EV_REPLACE; end
                default: ev_valid = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/msi_transition.sv
module msi_transition
    import msi_pkg::*;
(
    input  line_state_e cur,
    input  event_e      ev,
    output line_state_e nxt,
    output action_e     act
);
    always_comb begin
        nxt = cur;
        act = ACT_NONE;
        unique case (cur)
            LS_INV: begin
                if (ev == EV_READ)       nxt = LS_WAIT_RD;
                else if (ev == EV_WRITE) nxt = LS_WAIT_RDX_I;
            end
            LS_SHD: begin
                if (ev == EV_WRITE)        nxt = LS_WAIT_RDX_S;
                else if (ev == EV_REPLACE) nxt = LS_INV;
                else if (ev == EV_SNP_RDX) nxt = LS_INV;
            end
            LS_MOD: begin
                if (ev == EV_REPLACE) nxt = LS_WAIT_WB;
                else if (ev == EV_SNP_RD) begin
                    nxt = LS_SHD;
                    act = ACT_FLUSH;
                end else if (ev == EV_SNP_RDX) begin
                    nxt = LS_INV;
                    act = ACT_FLUSH;
                end
            end
            LS_WAIT_RD: begin
                if (ev == EV_GRANT) begin
                    nxt = LS_SHD;
                    act = ACT_FILL;
                end
            end
            LS_WAIT_RDX_I: begin
                if (ev == EV_GRANT) begin
                    nxt = LS_MOD;
                    act = ACT_FILL;
                end
            end
            LS_WAIT_RDX_S: begin
                if (ev == EV_GRANT) begin
                    nxt = LS_MOD;
                    act = ACT_UPGRADE;
                end else if (ev == EV_SNP_RDX) begin
                    nxt = LS_WAIT_RDX_I;
                end
            end
            LS_WAIT_WB: begin
                if (ev == EV_GRANT || ev == EV_SNP_RD || ev == EV_SNP_RDX) begin
                    nxt = LS_INV;
                    act = ACT_FLUSH;
                end
            end
            default: nxt = LS_INV;
        endcase
    end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_stall,
    input  logic              snp_valid,
    input  logic              snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [1:0]        rec_init,
    output logic [1:0]        rec_final,
    output logic [2:0]        rec_input,
    output logic [1:0]        rec_action
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              pend_busy_q;
    logic [ADDR_W-1:0] pend_addr_q;

    logic              ev_valid;
    event_e            ev_kind;
    logic [ADDR_W-1:0] ev_addr;
    logic [IDX_W-1:0]  ev_idx;
    logic [TAG_W-1:0]  ev_tag;

    line_state_e       slot_state;
    logic [TAG_W-1:0]  slot_tag;
    line_state_e       eff_state;
    line_state_e       nxt_state;
    action_e           nxt_act;

    logic              tag_hit;
    logic              is_cpu_ev;
    logic              conflict;
    logic              ev_ok;
    logic              wr_en;
    logic              arch_change;

    msi_event_select #(.ADDR_W(ADDR_W)) u_sel (
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op),
        .cpu_addr  (cpu_addr),
        .snp_valid (snp_valid),
        .snp_op    (snp_op),
        .snp_addr  (snp_addr),
        .bus_grant (bus_grant),
        .pend_busy (pend_busy_q),
        .pend_addr (pend_addr_q),
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind),
        .ev_addr   (ev_addr)
    );

    assign ev_idx = ev_addr[IDX_W-1:0];
    assign ev_tag = ev_addr[ADDR_W-1:IDX_W];

    msi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ev_idx),
        .rd_state (slot_state),
        .rd_tag   (slot_tag),
        .wr_en    (wr_en),
        .wr_idx   (ev_idx),
        .wr_state (nxt_state),
        .wr_tag   (ev_tag)
    );

    // Lookup and acceptance
    always_comb begin
        tag_hit   = (slot_tag == ev_tag);
        eff_state = tag_hit ? slot_state : LS_INV;
        is_cpu_ev = (ev_kind == EV_READ) || (ev_kind == EV_WRITE) ||
                    (ev_kind == EV_REPLACE);
        conflict  = is_cpu_ev && (ev_kind != EV_REPLACE) && !tag_hit &&
                    (slot_state != LS_INV);
        ev_ok     = ev_valid && !conflict;
    end

    msi_transition u_next (
        .cur (eff_state),
        .ev  (ev_kind),
        .nxt (nxt_state),
        .act (nxt_act)
    );

    assign wr_en       = ev_ok && (nxt_state != eff_state);
    assign arch_change = wr_en && (arch_of(eff_state) != arch_of(nxt_state));
    assign cpu_stall   = cpu_valid &&
                         (pend_busy_q || snp_valid || (ev_valid && conflict));
    assign bus_req     = pend_busy_q;

    // Outstanding-operation register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_busy_q <= 1'b0;
            pend_addr_q <= '0;
        end else if (wr_en) begin
            if (is_waiting(nxt_state)) begin
                pend_busy_q <= 1'b1;
                pend_addr_q <= ev_addr;
            end else if (is_waiting(eff_state)) begin
                pend_busy_q <= 1'b0;
            end
        end
    end

    // Transition record outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_valid  <= 1'b0;
            rec_addr   <= '0;
            rec_init   <= AS_I;
            rec_final  <= AS_I;
            rec_input  <= EV_READ;
            rec_action <= ACT_NONE;
        end else begin
            rec_valid <= arch_change;
            if (arch_change) begin
                rec_addr   <= ev_addr;
                rec_init   <= arch_of(eff_state);
                rec_final  <= arch_of(nxt_state);
                rec_input  <= ev_kind;
                rec_action <= nxt_act;
            end
        end
    end

endmodule

// File: rtl/msi_line_ctrl_checker.sv
module msi_line_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_valid,
    input logic       cpu_stall,
    input logic       snp_valid,
    input logic       bus_grant,
    input logic       bus_req,
    input logic       rec_valid,
    input logic [1:0] rec_init,
    input logic [1:0] rec_final,
    input logic [2:0] rec_input,
    input logic [1:0] rec_action
);
    assert_grant_clears_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant && !snp_valid) |=> !bus_req);

    assert_grant_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant && !snp_valid) |=> (rec_valid && rec_input == 3'd5));

    assert_req_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(cpu_valid && !cpu_stall));

    assert_stall_while_waiting_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && cpu_valid) |-> cpu_stall);

    assert_quiet_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_valid && !snp_valid && !(bus_req && bus_grant)) |=> !rec_valid);

    assert_snoop_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> (!rec_valid || rec_input == 3'd3 || rec_input == 3'd4));

    assert_flush_from_mod_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_action == 2'd3) |-> (rec_init == 2'd2));

    assert_record_changes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_init != rec_final));

endmodule

bind msi_line_ctrl msi_line_ctrl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_stall  (cpu_stall),
    .snp_valid  (snp_valid),
    .bus_grant  (bus_grant),
    .bus_req    (bus_req),
    .rec_valid  (rec_valid),
    .rec_init   (rec_init),
    .rec_final  (rec_final),
    .rec_input  (rec_input),
    .rec_action (rec_action)
);

// File: tb/msi_line_ctrl_bench.sv
`timescale 1ns/1ps
module msi_line_ctrl_bench;
    localparam int ADDR_W = 8;
    localparam int A = 8'h10;   // slot 0
    localparam int B = 8'h21;   // slot 1
    localparam int C = 8'h32;   // slot 2
    localparam int D = 8'h14;   // slot 0, other tag than A

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0;
    logic [1:0]        cpu_op = '0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_stall;
    logic              snp_valid = 1'b0;
    logic              snp_op = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              bus_grant = 1'b0;
    logic              bus_req;
    logic              rec_valid;
    logic [ADDR_W-1:0] rec_addr;
    logic [1:0]        rec_init;
    logic [1:0]        rec_final;
    logic [2:0]        rec_input;
    logic [1:0]        rec_action;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    msi_line_ctrl u_msi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .bus_grant(bus_grant), .bus_req(bus_req),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_init(rec_init),
        .rec_final(rec_final), .rec_input(rec_input), .rec_action(rec_action)
    );

    function automatic logic [45:0] mk(int req, bit cv, int cop, int caddr,
                                       bit sv, bit sop, int saddr, bit g,
                                       bit st, bit rv, int ei, int ef, int ein,
                                       int eact, int eaddr, bit breq);
        return {4'(req), cv, 2'(cop), 8'(caddr), sv, sop, 8'(saddr), g,
                st, rv, 2'(ei), 2'(ef), 3'(ein), 2'(eact), 8'(eaddr), breq};
    endfunction

    // Fields: req, cpu(v,op,addr), snoop(v,op,addr), grant,
    //         exp stall, rec_valid, init, final, input, action, addr, bus_req
    localparam int NV = 32;
    localparam logic [45:0] VECS [NV] = '{
        mk(2, 1,0,A, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R2 read miss waits
        mk(10,1,0,B, 0,0,0, 0,  1,0,0,0,0,0,0, 1),   // R10 stalled while waiting
        mk(2, 0,0,0, 0,0,0, 1,  0,1,0,1,5,1,A, 0),   // R2 grant fills S
        mk(11,1,0,A, 0,0,0, 0,  0,0,0,0,0,0,0, 0),   // R11 read hit
        mk(5, 0,0,0, 1,0,A, 0,  0,0,0,0,0,0,0, 0),   // R5 Bus_Rd in S
        mk(3, 1,1,A, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R3 write in S waits
        mk(7, 0,0,0, 1,1,A, 0,  0,1,1,0,4,0,A, 1),   // R7 RdX while waiting
        mk(7, 0,0,0, 0,0,0, 1,  0,1,0,2,5,1,A, 0),   // R7 grant I->M
        mk(11,1,1,A, 0,0,0, 0,  0,0,0,0,0,0,0, 0),   // R11 write hit
        mk(5, 0,0,0, 1,0,A, 0,  0,1,2,1,3,3,A, 0),   // R5 Bus_Rd in M
        mk(6, 0,0,0, 1,1,A, 0,  0,1,1,0,4,0,A, 0),   // R6 RdX in S
        mk(3, 1,1,B, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R3 write miss
        mk(9, 0,0,0, 1,0,C, 1,  0,0,0,0,0,0,0, 1),   // R9 grant with snoop
        mk(3, 0,0,0, 0,0,0, 1,  0,1,0,2,5,1,B, 0),   // R3 grant I->M
        mk(4, 1,2,B, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R4 replace M waits
        mk(4, 0,0,0, 0,0,0, 1,  0,1,2,0,5,3,B, 0),   // R4 writeback done
        mk(3, 1,1,C, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R3
        mk(3, 0,0,0, 0,0,0, 1,  0,1,0,2,5,1,C, 0),   // R3
        mk(4, 1,2,C, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R4
        mk(8, 0,0,0, 1,1,C, 0,  0,1,2,0,4,3,C, 0),   // R8 snoop ends writeback
        mk(2, 1,0,A, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R2
        mk(2, 0,0,0, 0,0,0, 1,  0,1,0,1,5,1,A, 0),   // R2
        mk(10,1,0,D, 0,0,0, 0,  1,0,0,0,0,0,0, 0),   // R10 tag conflict
        mk(11,0,0,0, 1,1,D, 0,  0,0,0,0,0,0,0, 0),   // R11 snoop tag mismatch
        mk(11,1,0,A, 0,0,0, 0,  0,0,0,0,0,0,0, 0),   // R11 hit
        mk(4, 1,2,A, 0,0,0, 0,  0,1,1,0,2,0,A, 0),   // R4 replace S
        mk(11,1,2,A, 0,0,0, 0,  0,0,0,0,0,0,0, 0),   // R11 replace I
        mk(3, 1,1,D, 0,0,0, 0,  0,0,0,0,0,0,0, 1),   // R3 new tag
        mk(3, 0,0,0, 0,0,0, 1,  0,1,0,2,5,1,D, 0),   // R3
        mk(11,0,0,0, 1,1,A, 0,  0,0,0,0,0,0,0, 0),   // R11 mismatch
        mk(6, 0,0,0, 1,1,D, 0,  0,1,2,0,4,3,D, 0),   // R6 RdX in M
        mk(10,1,0,B, 1,0,C, 0,  1,0,0,0,0,0,0, 0)    // R10 snoop blocks cpu
    };

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cpu_valid = 1'b0; cpu_op = '0; cpu_addr = '0;
        snp_valid = 1'b0; snp_op = 1'b0; snp_addr = '0;
        bus_grant = 1'b0;
    endtask

    // Drive at a falling edge, check the stall before the rising edge,
    // check registered outputs 1 ns after it, return at the next falling edge.
    task automatic step(logic [45:0] v);
        string rq;
        rq = $sformatf("R%0d", v[45:42]);
        cpu_valid = v[41]; cpu_op = v[40:39]; cpu_addr = v[38:31];
        snp_valid = v[30]; snp_op = v[29]; snp_addr = v[28:21];
        bus_grant = v[20];
        #1;
        chk(rq, "cpu_stall", int'(cpu_stall), int'(v[19]));
        @(posedge clk); #1;
        chk(rq, "rec_valid", int'(rec_valid), int'(v[18]));
        chk(rq, "bus_req", int'(bus_req), int'(v[0]));
        if (v[18]) begin
            chk(rq, "rec_init", int'(rec_init), int'(v[17:16]));
            chk(rq, "rec_final", int'(rec_final), int'(v[15:14]));
            chk(rq, "rec_input", int'(rec_input), int'(v[13:11]));
            chk(rq, "rec_action", int'(rec_action), int'(v[10:9]));
            chk(rq, "rec_addr", int'(rec_addr), int'(v[8:1]));
        end
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "bus_req in reset", int'(bus_req), 0);
        chk("R1", "rec_valid in reset", int'(rec_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "bus_req after reset", int'(bus_req), 0);
        chk("R1", "cpu_stall idle", int'(cpu_stall), 0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
        end

        // R12: ignored cpu_op code 3 does nothing
        step(mk(12, 1,3,B, 0,0,0, 0,  0,0,0,0,0,0,0, 0));

        // R1: reset erases state. Fill B as Shared, then reset mid-run.
        step(mk(1, 1,0,B, 0,0,0, 0,  0,0,0,0,0,0,0, 1));
        step(mk(1, 0,0,0, 0,0,0, 1,  0,1,0,1,5,1,B, 0));
        step(mk(1, 1,0,C, 0,0,0, 0,  0,0,0,0,0,0,0, 1));
        rst_n = 1'b0;
        #1;
        chk("R1", "bus_req mid-run reset", int'(bus_req), 0);
        chk("R1", "rec_valid mid-run reset", int'(rec_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // B would be S->M UPGRADE if the old state survived; expect I->M FILL.
        step(mk(1, 1,1,B, 0,0,0, 0,  0,0,0,0,0,0,0, 1));
        step(mk(1, 0,0,0, 0,0,0, 1,  0,1,0,2,5,1,B, 0));

        // R9: grant with no operation waiting is ignored
        step(mk(9, 0,0,0, 0,0,0, 1,  0,0,0,0,0,0,0, 0));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule